// File: doc/BRIEF.md
# Configurable Serial Character Transmitter

This block takes one character at a time from a parallel valid/ready interface and shifts it out on a single line as a framed serial character. The frame shape is chosen at run time. Each frame has a low start bit and 5 to 9 data bits sent least significant first. An optional even or odd parity bit follows, then one or two high stop bits. Between frames the line rests high.

Timing comes from an external strobe, `baud_tick`, which marks half-bit intervals. Each bit lasts two strobes. In asynchronous mode only the data line is meaningful. In synchronous mode the block also drives a serial clock that toggles on every strobe during a frame. The polarity input picks which clock edge carries data changes. A new character can be accepted in the cycle that ends the final stop bit, so frames can follow each other with no idle time.

Top module: `sertx_top`

## Requirements
- R1: After reset and between frames, `txd` is 1, `busy` is 0, `in_ready` is 1 and `sclk` equals `cfg_pol`.
- R2: A frame begins with one 0 start bit, followed by the data bits of `in_data`, bit 0 first. The count is set by `cfg_len`: 0 gives 5 bits, 1 gives 6, 2 gives 7, 3 gives 8, and 4 to 7 give 9. Data bits above the chosen count are not sent.
- R3: When `cfg_par[1]` is 1, one parity bit follows the last data bit. With `cfg_par[0]`=0 it is the XOR of the data bits sent (even parity); with `cfg_par[0]`=1 it is the inverse of that XOR (odd parity). When `cfg_par[1]` is 0, no parity bit is sent.
- R4: The frame ends with stop bits at 1: one stop bit when `cfg_stop2` is 0, two when it is 1.
- R5: Each bit lasts exactly two `baud_tick` strobes counted after the accepting cycle. `txd` changes only in the cycle after an accept or a strobe.
- R6: `in_ready` is 1 in idle, and during a frame only in the cycle whose strobe ends the final stop bit. An accept in that cycle drives the next start bit in the following cycle, with no idle gap.
- R7: With `cfg_sync`=1, `sclk` equals `!cfg_pol` from the start of each bit until its middle strobe, and equals `cfg_pol` for the second half. Data therefore changes on the rising edge when `cfg_pol`=0 and on the falling edge when `cfg_pol`=1.
- R8: With `cfg_sync`=0, `sclk` stays at `cfg_pol` during frames.
- R9: `busy` is 1 from the cycle after an accept until the final stop bit ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_data | input | DATA_W | Character to send |
| in_valid | input | 1 | Character present |
| in_ready | output | 1 | Character accepted when high together with `in_valid` |
| cfg_len | input | 3 | Data length code |
| cfg_par | input | 2 | Bit 1 enables parity, bit 0 selects odd |
| cfg_stop2 | input | 1 | Two stop bits when high |
| cfg_sync | input | 1 | Enables the serial clock output |
| cfg_pol | input | 1 | Serial clock rest level and edge choice |
| baud_tick | input | 1 | Half-bit strobe |
| txd | output | 1 | Serial data line |
| sclk | output | 1 | Serial clock |
| busy | output | 1 | A frame is in progress |

## Verification
The hardest case to reach is the handover between frames. Here the final strobe of one frame and the acceptance of the next character fall in the same cycle, and the timer reload must win over the strobe. The driver holds the next character valid while the current frame is still being sent, so the accept lands exactly on that closing strobe. The monitor counts strobes from each accept, and any gap or lost half-bit shifts every later sample. The same back-to-back pattern runs in synchronous mode, where the clock must go straight from its mid-bit level into the next start bit.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SEND = 1'b1
  } tx_state_e;

  typedef struct packed {
    logic par_en;
    logic par_odd;
    logic stop2;
  } tx_fmt_s;

endpackage

// File: rtl/sertx_parity.sv
module sertx_parity #(
  parameter int DATA_W = 9,
  parameter int CNT_W  = 4
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [CNT_W-1:0]  dlen_i,
  input  logic              odd_i,
  output logic              par_o
);

  logic [DATA_W-1:0] mask;

  // one mask bit per data position: set when the position is sent
  for (genvar g = 0; g < DATA_W; g++) begin : g_mask
    assign mask[g] = (CNT_W'(g) < dlen_i);
  end

  assign par_o = (^(data_i & mask)) ^ odd_i;

endmodule

// File: rtl/sertx_framer.sv
module sertx_framer
  import sertx_pkg::*;
#(
  parameter int DATA_W   = 9,
  parameter int DATA_MIN = 5,
  parameter int FRAME_W  = DATA_W + 4,
  parameter int CNT_W    = $clog2(FRAME_W + 1)
) (
  input  logic [DATA_W-1:0]  data_i,
  input  logic [2:0]         len_code_i,
  input  tx_fmt_s            fmt_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic [CNT_W-1:0]   nbits_o
);

  localparam int LONG_CODE = DATA_W - DATA_MIN;

  logic [CNT_W-1:0] dlen;
  logic             par_bit;

  always_comb begin
    if (int'(len_code_i) >= LONG_CODE) begin
      dlen = CNT_W'(DATA_W);
    end else begin
      dlen = CNT_W'(len_code_i) + CNT_W'(DATA_MIN);
    end
  end

  sertx_parity #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
  ) u_par (
    .data_i (data_i),
    .dlen_i (dlen),
    .odd_i  (fmt_i.par_odd),
    .par_o  (par_bit)
  );

  // frame vector, bit 0 goes first; unused upper positions stay high
  always_comb begin
    frame_o    = '1;
    frame_o[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (CNT_W'(i) < dlen) begin
        frame_o[1+i] = data_i[i];
      end
    end
    if (fmt_i.par_en) begin
      frame_o[dlen + CNT_W'(1)] = par_bit;
    end
  end

  assign nbits_o = CNT_W'(2) + dlen + CNT_W'(fmt_i.par_en) + CNT_W'(fmt_i.stop2);

endmodule

// File: rtl/sertx_bit_timer.sv
module sertx_bit_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_cnt_i,
  input  logic             tick_i,
  input  logic             active_i,
  output logic             bit_end_o,
  output logic             last_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             half_q, half_d;
  logic             en;

  always_comb begin
    cnt_d  = cnt_q;
    half_d = half_q;
    if (load_i) begin
      cnt_d  = load_cnt_i;
      half_d = 1'b0;
    end else if (active_i && tick_i) begin
      half_d = ~half_q;
      if (half_q) begin
        cnt_d = cnt_q - CNT_W'(1);
      end
    end
  end

  assign en = load_i | (active_i & tick_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      half_q <= 1'b0;
    end else if (en) begin
      cnt_q  <= cnt_d;
      half_q <= half_d;
    end
  end

  assign bit_end_o = active_i & tick_i & half_q;
  assign last_o    = (cnt_q == CNT_W'(1));

  // R4
  cnt_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_i |-> (cnt_q != '0));

endmodule

// File: rtl/sertx_sclk.sv
module sertx_sclk (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_i,
  input  logic pol_i,
  input  logic active_i,
  input  logic load_i,
  input  logic adv_i,
  input  logic done_i,
  output logic sclk_o
);

  logic sclk_q, sclk_d;

  always_comb begin
    if (!sync_i || (!active_i && !load_i)) begin
      sclk_d = pol_i;
    end else if (load_i) begin
      sclk_d = ~pol_i;
    end else if (done_i) begin
      sclk_d = pol_i;
    end else if (adv_i) begin
      sclk_d = ~sclk_q;
    end else begin
      sclk_d = sclk_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
    end else begin
      sclk_q <= sclk_d;
    end
  end

  assign sclk_o = sclk_q;

  // R7
  sclk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_i && active_i && !adv_i && !load_i) |=> $stable(sclk_q));

endmodule

// File: rtl/sertx_top.sv
module sertx_top
  import sertx_pkg::*;
#(
  parameter int DATA_W   = 9,
  parameter int DATA_MIN = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [2:0]        cfg_len,
  input  logic [1:0]        cfg_par,
  input  logic              cfg_stop2,
  input  logic              cfg_sync,
  input  logic              cfg_pol,
  input  logic              baud_tick,
  output logic              txd,
  output logic              sclk,
  output logic              busy
);

  localparam int FRAME_W = DATA_W + 4;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_ln;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync_q <= 2'b00;
    end else begin
      rsync_q <= {rsync_q[0], 1'b1};
    end
  end

  assign rst_ln = rsync_q[1];

  tx_fmt_s            fmt;
  logic [FRAME_W-1:0] frame_w;
  logic [CNT_W-1:0]   nbits_w;
  logic               bit_end, last_bit, frame_end, accept, done;

  tx_state_e          state_q, state_d;
  logic               txd_q, txd_d;
  logic [FRAME_W-2:0] shreg_q, shreg_d;
  logic               reg_en;

  assign fmt = '{par_en: cfg_par[1], par_odd: cfg_par[0], stop2: cfg_stop2};

  sertx_framer #(
    .DATA_W   (DATA_W),
    .DATA_MIN (DATA_MIN),
    .FRAME_W  (FRAME_W),
    .CNT_W    (CNT_W)
  ) u_framer (
    .data_i     (in_data),
    .len_code_i (cfg_len),
    .fmt_i      (fmt),
    .frame_o    (frame_w),
    .nbits_o    (nbits_w)
  );

  sertx_bit_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_ln),
    .load_i     (accept),
    .load_cnt_i (nbits_w),
    .tick_i     (baud_tick),
    .active_i   (busy),
    .bit_end_o  (bit_end),
    .last_o     (last_bit)
  );

  assign frame_end = bit_end & last_bit;
  assign in_ready  = (state_q == ST_IDLE) | frame_end;
  assign accept    = in_valid & in_ready;
  assign done      = frame_end & ~accept;

  sertx_sclk u_sclk (
    .clk      (clk),
    .rst_n    (rst_ln),
    .sync_i   (cfg_sync),
    .pol_i    (cfg_pol),
    .active_i (busy),
    .load_i   (accept),
    .adv_i    (busy & baud_tick),
    .done_i   (done),
    .sclk_o   (sclk)
  );

  always_comb begin
    state_d = state_q;
    txd_d   = txd_q;
    shreg_d = shreg_q;
    if (accept) begin
      state_d = ST_SEND;
      txd_d   = frame_w[0];
      shreg_d = frame_w[FRAME_W-1:1];
    end else if (frame_end) begin
      state_d = ST_IDLE;
      txd_d   = 1'b1;
    end else if (bit_end) begin
      txd_d   = shreg_q[0];
      shreg_d = {1'b1, shreg_q[FRAME_W-2:1]};
    end
  end

  assign reg_en = accept | bit_end;

  always_ff @(posedge clk or negedge rst_ln) begin
    if (!rst_ln) begin
      state_q <= ST_IDLE;
      txd_q   <= 1'b1;
      shreg_q <= '1;
    end else if (reg_en) begin
      state_q <= state_d;
      txd_q   <= txd_d;
      shreg_q <= shreg_d;
    end
  end

  assign txd  = txd_q;
  assign busy = (state_q == ST_SEND);

  // R1
  idle_line_chk: assert property (@(posedge clk) disable iff (!rst_ln)
    (state_q == ST_IDLE) |-> txd_q);

  // R6
  start_bit_chk: assert property (@(posedge clk) disable iff (!rst_ln)
    accept |=> (!txd && busy));

  // R5
  txd_hold_chk: assert property (@(posedge clk) disable iff (!rst_ln)
    (busy && !baud_tick) |=> $stable(txd));

endmodule

// File: tb/sertx_top_tb.sv
module sertx_top_tb_top;

  localparam int DW = 9;

  typedef struct {
    logic [15:0] bits;
    int          n;
    logic        sync;
    logic        pol;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [2:0]    cfg_len = 3'd3;
  logic [1:0]    cfg_par = 2'b00;
  logic          cfg_stop2 = 1'b0;
  logic          cfg_sync = 1'b0;
  logic          cfg_pol = 1'b0;
  logic          baud_tick = 1'b0;
  logic          txd, sclk, busy;

  int   errs = 0;
  int   checks = 0;
  exp_t q[$];

  always #5 clk = ~clk;

  sertx_top #(.DATA_W(DW), .DATA_MIN(5)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .cfg_len(cfg_len), .cfg_par(cfg_par),
    .cfg_stop2(cfg_stop2), .cfg_sync(cfg_sync), .cfg_pol(cfg_pol),
    .baud_tick(baud_tick), .txd(txd), .sclk(sclk), .busy(busy)
  );

  // half-bit strobe every fourth cycle
  initial begin
    int c = 0;
    forever begin
      @(posedge clk);
      #1;
      c = (c + 1) % 4;
      baud_tick = (c == 0);
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic exp_t build(input logic [DW-1:0] d);
    exp_t e;
    int   nd;
    logic p;
    nd = (cfg_len >= 3'd4) ? 9 : int'(cfg_len) + 5;
    e.bits = '1;
    e.bits[0] = 1'b0;
    p = 1'b0;
    for (int i = 0; i < nd; i++) begin
      e.bits[1+i] = d[i];
      p = p ^ d[i];
    end
    e.n = 1 + nd;
    if (cfg_par[1]) begin
      e.bits[e.n] = p ^ cfg_par[0];
      e.n++;
    end
    e.n = e.n + (cfg_stop2 ? 2 : 1);
    e.sync = cfg_sync;
    e.pol  = cfg_pol;
    return e;
  endfunction

  // driver: pushes the expected frame, then offers the character
  task automatic send(input logic [DW-1:0] d);
    bit acc;
    q.push_back(build(d));
    in_data  = d;
    in_valid = 1'b1;
    do begin
      @(negedge clk);
      acc = in_ready;
      @(posedge clk);
      #1;
    end while (!acc);
    in_valid = 1'b0;
  endtask

  // monitor state
  bit          mon_active = 0;
  bit          samp_pend = 0;
  bit          start_pend = 0;
  int          tcnt = 0;
  int          idx = 0;
  logic [15:0] got;
  bit          sclk_bad, busy_bad;
  exp_t        cur;

  always @(negedge clk) begin
    if (rst_n) begin
      if (samp_pend) begin
        samp_pend = 0;
        got[idx] = txd;
        idx++;
        if (cur.sync && sclk !== cur.pol) sclk_bad = 1;
        if (busy !== 1'b1) busy_bad = 1;
        if (idx == cur.n) begin
          // R2 R3 R4 R5 R6: framed bits at mid-bit positions
          check(got[15:0] == cur.bits || ((got ^ cur.bits) & ((16'd1 << cur.n) - 16'd1)) == 16'd0,
                "R2 R3 R4 R5 R6 frame bits", int'(got), int'(cur.bits));
          if (cur.sync) check(!sclk_bad, "R7 sync clock levels", int'(sclk_bad), 0);
          else          check(!sclk_bad, "R8 async clock rest", int'(sclk_bad), 0);
          check(!busy_bad, "R9 busy during frame", int'(busy_bad), 0);
          mon_active = 0;
        end
      end
      if (start_pend) begin
        start_pend = 0;
        if (cur.sync && sclk !== ~cur.pol) sclk_bad = 1;
      end
      if (mon_active && !cur.sync && sclk !== cur.pol) sclk_bad = 1;
      if (mon_active && baud_tick) begin
        tcnt++;
        if (tcnt % 2 == 1) samp_pend = 1;
        else if (tcnt < 2 * cur.n) start_pend = 1;
      end
      if (in_valid && in_ready) begin
        if (q.size() == 0) begin
          check(0, "R6 unexpected accept", 1, 0);
        end else begin
          cur = q.pop_front();
          mon_active = 1;
          tcnt = 0;
          idx = 0;
          got = '1;
          sclk_bad = 0;
          busy_bad = 0;
          start_pend = 1;
        end
      end
    end
  end

  task automatic wait_idle();
    do @(negedge clk); while (busy || mon_active || q.size() != 0);
    @(posedge clk);
    #1;
  endtask

  task automatic set_cfg(input logic [2:0] l, input logic [1:0] p, input logic s2,
                         input logic sy, input logic po);
    wait_idle();
    cfg_len = l; cfg_par = p; cfg_stop2 = s2; cfg_sync = sy; cfg_pol = po;
    repeat (2) @(posedge clk);
    #1;
  endtask

  task automatic check_idle(input string tag);
    @(negedge clk);
    check(txd === 1'b1, {tag, " R1 idle txd"}, int'(txd), 1);
    check(busy === 1'b0, {tag, " R1 idle busy"}, int'(busy), 0);
    check(in_ready === 1'b1, {tag, " R1 idle ready"}, int'(in_ready), 1);
    check(sclk === cfg_pol, {tag, " R1 idle sclk"}, int'(sclk), int'(cfg_pol));
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog expired, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    check_idle("reset");

    // async formats
    set_cfg(3'd3, 2'b00, 1'b0, 1'b0, 1'b0);
    send(9'h0A5);
    set_cfg(3'd0, 2'b10, 1'b0, 1'b0, 1'b0);   // R2 R3: 5 bits even, upper bits ignored
    send(9'h1F3);
    set_cfg(3'd4, 2'b11, 1'b1, 1'b0, 1'b0);   // R3 R4: 9 bits odd, 2 stops
    send(9'h155);
    set_cfg(3'd2, 2'b10, 1'b1, 1'b0, 1'b1);   // R8: pol 1 in async
    send(9'h07F);
    set_cfg(3'd1, 2'b11, 1'b0, 1'b0, 1'b0);
    send(9'h000);
    set_cfg(3'd7, 2'b01, 1'b0, 1'b0, 1'b0);   // R2: code 7 gives 9 bits
    send(9'h1FF);

    // R6: back-to-back frames and ready low mid-frame
    set_cfg(3'd3, 2'b00, 1'b0, 1'b0, 1'b0);
    send(9'h0C3);
    @(negedge clk);
    while (baud_tick) @(negedge clk);
    check(in_ready === 1'b0, "R6 ready low mid-frame", int'(in_ready), 0);
    @(posedge clk);
    #1;
    send(9'h03C);
    send(9'h0FF);

    // R7 synchronous mode, both polarities
    set_cfg(3'd3, 2'b10, 1'b0, 1'b1, 1'b0);
    send(9'h096);
    send(9'h169);
    set_cfg(3'd1, 2'b11, 1'b1, 1'b1, 1'b1);
    send(9'h02D);
    send(9'h012);
    wait_idle();
    check_idle("sync");

    wait_idle();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule